// File: doc/BRIEF.md
# Oscillator Fault Fallback Clock Selector

This block picks the clock source for a main clock and a subsystem clock from three oscillators: an internal digitally controlled oscillator (DCO), a first crystal that runs in a low-frequency or a high-frequency mode, and an optional second crystal. The analog side is modelled by one valid input per crystal. The DCO is modelled by a tap register that a frequency-locked loop steps toward a programmed target. The outputs are select codes for a glitch-free clock mux that sits downstream.

Every oscillator has a sticky fault flag, and any fault also sets a global fault flag. While the global flag is set, both clock outputs are forced to the DCO, whatever software has programmed. The programmed sources take effect only after software clears the global flag. That clear is refused while any per-oscillator flag is still set, so software must first clear each fault once its cause is gone.

Top module: `osc_fallback_ctrl`

## Requirements
- R1: After reset, both programmed selects are DCO (code 0) and the first crystal is enabled in low-frequency mode. The second crystal is disabled and the DCO tap is 0. The flags register reads 0x09 (low-frequency crystal fault and DCO fault set), and the global fault flag is 1.
- R2: While the global fault flag is 1, both mainSrc and subSrc are 0 (DCO), whatever the programmed selects are.
- R3: The fault flags are at address 1: bit0 low-frequency crystal, bit1 high-frequency crystal, bit2 second crystal, bit3 DCO. A flag is set on every cycle in which its fault condition holds. A write to address 1 clears each flag whose data bit is 0, unless its condition holds in that cycle, in which case the set wins. A data bit of 1 leaves its flag unchanged.
- R4: A write of 0 to bit0 of address 2 clears the global flag only when all four per-oscillator flags are 0 before that write. Otherwise the flag stays 1. The global flag is readable at address 2, bit0.
- R5: With the global flag at 0, each output carries its programmed select: 1 = first crystal, 2 = second crystal, 0 and 3 = DCO.
- R6: The DCO fault condition holds while the tap is 0 or at its maximum (31 by default).
- R7: A write to address 3 sets the DCO target tap (data bits 4:0), and address 3 reads the current tap. On every 32nd refTick pulse, the tap moves one step toward the target.
- R8: A disabled second crystal never sets its fault flag, whatever xt2Valid is.
- R9: When a crystal fault condition arises, the global flag is 1 after the next clock edge, even if a global clear is written in the same cycle, and the outputs return to the DCO.
- R10: The control register is at address 0: bits 1:0 main select, bits 3:2 subsystem select, bit4 high-frequency mode, bit5 first crystal enable, bit6 second crystal enable. It reads back as written, with bit7 = 0. A crystal fault condition is: enabled, in the mode that matches the flag, and with its valid input low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| xt1Valid | input | 1 | First crystal oscillating |
| xt2Valid | input | 1 | Second crystal oscillating |
| refTick | input | 1 | Reference clock tick for the FLL |
| mainSrc | output | 2 | Effective main clock source code |
| subSrc | output | 2 | Effective subsystem clock source code |
| oscFaultIrq | output | 1 | Global oscillator fault flag |

## Verification
Two collisions matter here. A fault condition can coincide with a software clear of its own flag, and a new crystal fault can coincide with a write that clears the global flag. The bench drives xt1Valid low in the same cycle as the clearing write in both cases. The reference model, in which the set always wins, must agree with the design on the flags, the global flag and both source outputs after that edge.

// File: rtl/osc_fb_pkg.sv
package osc_fb_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int NUM_OSC = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_FAULT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_GLOBAL = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_TAP    = 2'd3;

  typedef enum logic [1:0] {
    SRC_DCO = 2'd0,
    SRC_XT1 = 2'd1,
    SRC_XT2 = 2'd2,
    SRC_RSV = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrFault;
    logic wrGlobal;
    logic wrTarget;
    logic [DATA_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/osc_fb_regif.sv
module osc_fb_regif
  import osc_fb_pkg::*;
#(
  parameter int TAP_W = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] ctrlRd,
  input  logic [NUM_OSC-1:0] fltFlags,
  input  logic              ofFlag,
  input  logic [TAP_W-1:0]  tap,
  output regStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData
);
  always_comb begin
    strobe          = '0;
    strobe.data     = wrData;
    strobe.wrCtrl   = wrEn && (addr == ADR_CTRL);
    strobe.wrFault  = wrEn && (addr == ADR_FAULT);
    strobe.wrGlobal = wrEn && (addr == ADR_GLOBAL);
    strobe.wrTarget = wrEn && (addr == ADR_TAP);
  end

  always_comb begin
    unique case (addr)
      ADR_CTRL:   rdData = ctrlRd;
      ADR_FAULT:  rdData = {{(DATA_W-NUM_OSC){1'b0}}, fltFlags};
      ADR_GLOBAL: rdData = {{(DATA_W-1){1'b0}}, ofFlag};
      default:    rdData = {{(DATA_W-TAP_W){1'b0}}, tap};
    endcase
  end
endmodule

// File: rtl/osc_fb_core.sv
module osc_fb_core
  import osc_fb_pkg::*;
#(
  parameter int TAP_W       = 5,
  parameter int REF_DIV     = 32,
  parameter int INIT_TARGET = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic              xt1Valid,
  input  logic              xt2Valid,
  input  logic              refTick,
  output logic [DATA_W-1:0] ctrlRd,
  output logic [NUM_OSC-1:0] fltFlags,
  output logic              ofFlag,
  output logic [TAP_W-1:0]  tap,
  output srcSel_e           mainSrc,
  output srcSel_e           subSrc
);
  localparam int CNT_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REF_DIV - 1);

  srcSel_e mainSel, subSel;
  logic xt1Hf, xt1On, xt2On;
  logic [TAP_W-1:0] target;
  logic [CNT_W-1:0] refCnt;
  logic [NUM_OSC-1:0] setCond, clrMask;
  logic globalClr;

  assign ctrlRd = {1'b0, xt2On, xt1On, xt1Hf, subSel, mainSel};

  always_comb begin
    setCond[0] = xt1On && !xt1Hf && !xt1Valid;
    setCond[1] = xt1On &&  xt1Hf && !xt1Valid;
    setCond[2] = xt2On && !xt2Valid;
    setCond[3] = (tap == '0) || (tap == TAP_MAX);
    clrMask    = strobe.wrFault ? ~strobe.data[NUM_OSC-1:0] : '0;
    globalClr  = strobe.wrGlobal && !strobe.data[0] && (fltFlags == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainSel <= SRC_DCO;
      subSel  <= SRC_DCO;
      xt1Hf   <= 1'b0;
      xt1On   <= 1'b1;
      xt2On   <= 1'b0;
    end else if (strobe.wrCtrl) begin
      mainSel <= srcSel_e'(strobe.data[1:0]);
      subSel  <= srcSel_e'(strobe.data[3:2]);
      xt1Hf   <= strobe.data[4];
      xt1On   <= strobe.data[5];
      xt2On   <= strobe.data[6];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fltFlags <= 4'b1001;
      ofFlag   <= 1'b1;
    end else begin
      fltFlags <= setCond | (fltFlags & ~clrMask);
      ofFlag   <= (|setCond) || (ofFlag && !globalClr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target <= TAP_W'(INIT_TARGET);
      refCnt <= '0;
      tap    <= '0;
    end else begin
      if (strobe.wrTarget) target <= strobe.data[TAP_W-1:0];
      if (refTick) begin
        if (refCnt == CNT_LAST) begin
          refCnt <= '0;
          if (tap < target)      tap <= tap + TAP_W'(1);
          else if (tap > target) tap <= tap - TAP_W'(1);
        end else begin
          refCnt <= refCnt + CNT_W'(1);
        end
      end
    end
  end

  function automatic srcSel_e effSrc(input srcSel_e sel, input logic fault);
    return (fault || sel == SRC_RSV) ? SRC_DCO : sel;
  endfunction

  assign mainSrc = effSrc(mainSel, ofFlag);
  assign subSrc  = effSrc(subSel, ofFlag);
endmodule

// File: rtl/osc_fallback_ctrl.sv
module osc_fallback_ctrl
  import osc_fb_pkg::*;
#(
  parameter int TAP_W       = 5,
  parameter int REF_DIV     = 32,
  parameter int INIT_TARGET = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        xt1Valid,
  input  logic        xt2Valid,
  input  logic        refTick,
  output logic [1:0]  mainSrc,
  output logic [1:0]  subSrc,
  output logic        oscFaultIrq
);
  regStrobe_t strobe;
  logic [DATA_W-1:0] ctrlRd;
  logic [NUM_OSC-1:0] fltFlags;
  logic ofFlag;
  logic [TAP_W-1:0] tapVal;
  srcSel_e mainEff, subEff;

  osc_fb_regif #(.TAP_W(TAP_W)) u_regif (
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .ctrlRd(ctrlRd),
    .fltFlags(fltFlags), .ofFlag(ofFlag), .tap(tapVal),
    .strobe(strobe), .rdData(rdData)
  );

  osc_fb_core #(.TAP_W(TAP_W), .REF_DIV(REF_DIV), .INIT_TARGET(INIT_TARGET)) u_core (
    .clk(clk), .rstN(rstN), .strobe(strobe), .xt1Valid(xt1Valid),
    .xt2Valid(xt2Valid), .refTick(refTick), .ctrlRd(ctrlRd),
    .fltFlags(fltFlags), .ofFlag(ofFlag), .tap(tapVal),
    .mainSrc(mainEff), .subSrc(subEff)
  );

  assign mainSrc     = mainEff;
  assign subSrc      = subEff;
  assign oscFaultIrq = ofFlag;
endmodule

// File: rtl/osc_fallback_chk.sv
module osc_fallback_chk #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mainSrc,
  input logic [1:0]       subSrc,
  input logic             oscFaultIrq,
  input logic [3:0]       fltFlags,
  input logic [TAP_W-1:0] tap
);
  a_r2_fallback_dco: assert property (@(posedge clk) disable iff (!rstN)
    oscFaultIrq |-> (mainSrc == 2'd0 && subSrc == 2'd0));

  a_r4_global_holds_flags: assert property (@(posedge clk) disable iff (!rstN)
    (|fltFlags) |-> oscFaultIrq);

  a_r6_dco_limit_flag: assert property (@(posedge clk) disable iff (!rstN)
    (tap == '0 || tap == {TAP_W{1'b1}}) |=> fltFlags[3]);

  a_r7_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tap) |-> (tap == $past(tap) + TAP_W'(1) || tap == $past(tap) - TAP_W'(1)));

  a_r9_fault_rearms: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|fltFlags[2:0]) |-> oscFaultIrq);
endmodule

bind osc_fallback_ctrl osc_fallback_chk #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rstN(rstN), .mainSrc(mainSrc), .subSrc(subSrc),
  .oscFaultIrq(oscFaultIrq), .fltFlags(fltFlags), .tap(tapVal)
);

// File: tb/sim_osc_fallback_ctrl.sv
`timescale 1ns/1ps
module sim_osc_fallback_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic xt1Valid = 1'b0;
  logic xt2Valid = 1'b0;
  logic refTick = 1'b0;
  logic [1:0] mainSrc, subSrc;
  logic oscFaultIrq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int mSel, sSel, hf, x1on, x2on, tgt, tap, rc, of;
  int flt[4];

  always #2 clk = ~clk;

  osc_fallback_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .xt1Valid(xt1Valid), .xt2Valid(xt2Valid),
    .refTick(refTick), .mainSrc(mainSrc), .subSrc(subSrc),
    .oscFaultIrq(oscFaultIrq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mSel = 0; sSel = 0; hf = 0; x1on = 1; x2on = 0;
    tgt = 4; tap = 0; rc = 0; of = 1;
    flt[0] = 1; flt[1] = 0; flt[2] = 0; flt[3] = 1;
  endtask

  function automatic int eff(input int sel);
    return (of == 1 || sel == 3) ? 0 : sel;
  endfunction

  function automatic int expRead(input int a);
    case (a)
      0: return (x2on << 6) | (x1on << 5) | (hf << 4) | (sSel << 2) | mSel;
      1: return (flt[3] << 3) | (flt[2] << 2) | (flt[1] << 1) | flt[0];
      2: return of;
      default: return tap;
    endcase
  endfunction

  // one clock: model advances with the inputs present before the edge
  task automatic tick();
    int s[4];
    int anySet, allClear, d;
    d = wrData;
    s[0] = (x1on == 1 && hf == 0 && !xt1Valid) ? 1 : 0;
    s[1] = (x1on == 1 && hf == 1 && !xt1Valid) ? 1 : 0;
    s[2] = (x2on == 1 && !xt2Valid) ? 1 : 0;
    s[3] = (tap == 0 || tap == 31) ? 1 : 0;
    anySet = s[0] | s[1] | s[2] | s[3];
    allClear = (flt[0] | flt[1] | flt[2] | flt[3]) == 0;
    @(posedge clk);
    if (!rstN) modelReset();
    else begin
      if (wrEn && addr == 2 && ((d & 1) == 0) && allClear) of = 0;
      if (anySet != 0) of = 1;
      for (int i = 0; i < 4; i++) begin
        if (wrEn && addr == 1 && ((d >> i) & 1) == 0) flt[i] = 0;
        if (s[i] != 0) flt[i] = 1;
      end
      if (refTick) begin
        if (rc == 31) begin
          rc = 0;
          if (tap < tgt) tap++;
          else if (tap > tgt) tap--;
        end else rc++;
      end
      if (wrEn && addr == 3) tgt = d & 31;
      if (wrEn && addr == 0) begin
        mSel = d & 3; sSel = (d >> 2) & 3; hf = (d >> 4) & 1;
        x1on = (d >> 5) & 1; x2on = (d >> 6) & 1;
      end
    end
    @(negedge clk);
    check("R2/R5 mainSrc model", mainSrc, eff(mSel));
    check("R2/R5 subSrc model", subSrc, eff(sSel));
    check("R4/R9 oscFaultIrq model", oscFaultIrq, of);
    check("R10 rdData model", rdData, expRead(addr));
  endtask

  task automatic regWrite(input int a, input int d);
    addr = 2'(a); wrData = 8'(d); wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic readAt(input int a);
    addr = 2'(a);
    #0.1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) tick();
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    readAt(0); check("R1 ctrl reset", rdData, 8'h20);
    readAt(1); check("R1 flags reset", rdData, 8'h09);
    readAt(2); check("R1 global reset", rdData, 8'h01);
    readAt(3); check("R1 tap reset", rdData, 8'h00);
    check("R1 main DCO", mainSrc, 0);

    // R2 program crystal HF while faulted
    regWrite(0, 8'h35);
    check("R2 main forced DCO", mainSrc, 0);
    tick();
    readAt(1); check("R3 HF flag set", rdData, 8'h0B);

    // R4 clear refused while flags set
    regWrite(2, 8'h00);
    check("R4 global stays set", oscFaultIrq, 1);

    // R3 clear crystal flags once valid; DCO stays (tap 0)
    xt1Valid = 1'b1;
    regWrite(1, 8'h00);
    readAt(1); check("R3 crystal flags cleared, R6 DCO kept", rdData, 8'h08);

    // R7 FLL stepping
    addr = 2'd3;
    refTick = 1'b1;
    repeat (31) tick();
    check("R7 tap before 32nd tick", rdData, 0);
    tick();
    check("R7 tap after 32nd tick", rdData, 1);
    refTick = 1'b0;

    regWrite(1, 8'h00);
    readAt(1); check("R6 DCO flag clears off limit", rdData, 8'h00);
    regWrite(2, 8'h00);
    check("R4 global clears", oscFaultIrq, 0);
    check("R5 main XT1", mainSrc, 1);
    check("R5 sub XT1", subSrc, 1);

    // R8 disabled second crystal
    regWrite(0, 8'h39);
    repeat (3) tick();
    readAt(1); check("R8 XT2 flag stays clear", rdData, 8'h00);
    check("R8 sub XT2", subSrc, 2);
    check("R8 global clear", oscFaultIrq, 0);

    // R5 reserved code
    regWrite(0, 8'h3B);
    check("R5 code 3 means DCO", mainSrc, 0);
    regWrite(0, 8'h35);

    // R9 fault with simultaneous global clear
    xt1Valid = 1'b0;
    regWrite(2, 8'h00);
    check("R9 global set despite clear", oscFaultIrq, 1);
    check("R9 main back to DCO", mainSrc, 0);
    readAt(1); check("R9 HF flag", rdData, 8'h02);

    // R3 flag clear colliding with condition, and write-one no effect
    regWrite(1, 8'h00);
    readAt(1); check("R3 set wins over clear", rdData, 8'h02);
    xt1Valid = 1'b1;
    regWrite(1, 8'h0F);
    readAt(1); check("R3 write one ignored", rdData, 8'h02);
    regWrite(1, 8'h00);
    regWrite(2, 8'h00);
    check("R5 recovered main", mainSrc, 1);

    // R6 upper limit
    regWrite(3, 31);
    refTick = 1'b1;
    addr = 2'd3;
    repeat (30 * 32 + 4) tick();
    refTick = 1'b0;
    check("R7 tap at max", rdData, 31);
    tick();
    readAt(1); check("R6 DCO flag at max", rdData, 8'h08);
    check("R6 global set at max", oscFaultIrq, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule